// File: doc/BRIEF.md
# Pixel PLL Divider Search Engine

This block chooses the divider settings of a pixel-clock PLL that runs from a fixed 120 MHz (120000 kHz) reference. It is given a requested pixel clock in kHz and a flag that says whether the panel link carries two channels. It then walks through every legal pair of post-divider P1 and input divider N. For each pair it works out the rounded feedback multiplier and drops any multiplier outside the legal window. It keeps the pair whose output frequency lands closest to the target.

After the walk, the winning multiplier is split into a coarse and a fine feedback field. The N, coarse and fine values are returned packed into one control word. P1 is returned as a one-hot select. Software or a sequencer raises `start` for one cycle and waits for `done`. It then reads the packed results, or sees `not_found` when no pair gave a legal multiplier.

Top module: `pll_div_search`

## Requirements
- R1: While reset is high, and afterwards until the first search completes, `busy`, `done` and `not_found` are low, and `fp_word` and `p1_onehot` read zero.
- R2: The search target T equals `pix_khz` when `dual_link` is 1, and `2*pix_khz` when `dual_link` is 0. Both inputs are sampled in the cycle that accepts `start`.
- R3: For P1 = 1..8 (outer loop) and N = 5..10 (inner loop), with D = N*P1*7, the multiplier is m = floor((T*D + 60000) / 120000). A pair whose m is below 77 or above 131 is never chosen.
- R4: The achieved frequency is F = floor(120000*m / D) and the error is |T - F|. A pair replaces the current best only when its error is strictly smaller, so among equal errors the earliest pair in loop order wins.
- R5: The chosen m is split into fine value M2 = ((m+3) mod 5) + 7 and coarse value M1 = (m - M2)/5.
- R6: `fp_word` bits 23:16 hold N-2, bits 15:8 hold M1-2 and bits 7:0 hold M2-2. Bits 31:24 are zero.
- R7: `p1_onehot` has only bit P1-1 set. Placed at bit 16 of a control register, it equals 0x10000 shifted left by P1-1.
- R8: When no pair passes the multiplier window, `not_found` is 1 and `fp_word` and `p1_onehot` are zero. Otherwise `not_found` is 0.
- R9: `busy` is high from the cycle after `start` is accepted until the result is ready. `done` is high for exactly one cycle, with `busy` low in that cycle. `done` rises at the 50th rising edge, counting the edge that accepts `start` as the first.
- R10: A `start` pulse while `busy` is high is ignored. The running search and its result use the target accepted first.
- R11: The result outputs change only in the cycle `done` is high, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted when idle) |
| pix_khz | input | 32 | Requested pixel clock in kHz |
| dual_link | input | 1 | 1: target is the pixel clock; 0: target is twice it |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| not_found | output | 1 | No pair produced a legal multiplier |
| fp_word | output | 32 | Packed N-2, M1-2, M2-2 fields |
| p1_onehot | output | 8 | One-hot post-divider select |

## Verification
The bench builds the engine with its default parameters: the 120000 kHz reference, P1 from 1 to 8, N from 5 to 10 and the 77..131 multiplier window. Under these parameters the reachable target band runs from about 16.5 MHz up to about 449 MHz. Random pixel clocks in both link modes land across that band, so every P1 value and every field combination gets exercised. Directed cases sit just outside the band on both sides to force the not-found path. A second start is issued mid-search, and the inputs are changed while idle to confirm that the results hold.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int unsigned REF_KHZ_D  = 120000;
    localparam int unsigned POSTDIV_D  = 7;
    localparam int unsigned P1_HI_D    = 8;
    localparam int unsigned N_LO_D     = 5;
    localparam int unsigned N_HI_D     = 10;
    localparam int unsigned M_LO_D     = 77;
    localparam int unsigned M_HI_D     = 131;
    localparam int unsigned XW         = 48;
    localparam int unsigned FW         = 8;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_WRAP = 2'd2
    } srch_state_e;

    typedef struct packed {
        logic [FW-1:0] p1;
        logic [FW-1:0] n;
    } cand_t;

    typedef struct packed {
        logic [FW-1:0] n_f;
        logic [FW-1:0] m1_f;
        logic [FW-1:0] m2_f;
    } fb_fields_t;

    // Split multiplier into coarse/fine parts and subtract the register bias.
    function automatic fb_fields_t pack_fields(input logic [FW-1:0] n,
                                               input logic [FW-1:0] m);
        fb_fields_t r;
        logic [FW-1:0] m2;
        logic [FW-1:0] m1;
        m2     = FW'((m + 8'd3) % 8'd5) + 8'd7;
        m1     = (m - m2) / 8'd5;
        r.n_f  = n - 8'd2;
        r.m1_f = m1 - 8'd2;
        r.m2_f = m2 - 8'd2;
        return r;
    endfunction

endpackage

// File: rtl/pll_cand_walk.sv
module pll_cand_walk
    import pll_search_pkg::*;
#(
    parameter int unsigned P1_HI = P1_HI_D,
    parameter int unsigned N_LO  = N_LO_D,
    parameter int unsigned N_HI  = N_HI_D
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  init,
    input  logic  step,
    output cand_t cand,
    output logic  last
);
    localparam logic [FW-1:0] P1_FIRST = FW'(1);
    localparam logic [FW-1:0] P1_LAST  = FW'(P1_HI);
    localparam logic [FW-1:0] N_FIRST  = FW'(N_LO);
    localparam logic [FW-1:0] N_LAST   = FW'(N_HI);

    assign last = (cand.p1 == P1_LAST) && (cand.n == N_LAST);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            cand.p1 <= P1_FIRST;
            cand.n  <= N_FIRST;
        end else if (step && !last) begin
            if (cand.n == N_LAST) begin
                cand.n  <= N_FIRST;
                cand.p1 <= cand.p1 + 8'd1;
            end else begin
                cand.n  <= cand.n + 8'd1;
            end
        end
    end
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
    import pll_search_pkg::*;
#(
    parameter int unsigned REF_KHZ = REF_KHZ_D,
    parameter int unsigned POSTDIV = POSTDIV_D,
    parameter int unsigned M_LO    = M_LO_D,
    parameter int unsigned M_HI    = M_HI_D
) (
    input  logic [XW-1:0] target,
    input  cand_t         cand,
    output logic          in_range,
    output logic [XW-1:0] err,
    output logic [FW-1:0] m_val
);
    localparam logic [XW-1:0] REF_X  = XW'(REF_KHZ);
    localparam logic [XW-1:0] HALF_X = XW'(REF_KHZ / 2);
    localparam logic [XW-1:0] PD_X   = XW'(POSTDIV);

    logic [XW-1:0] denom;
    logic [XW-1:0] mq;
    logic [XW-1:0] achieved;

    always_comb begin
        denom    = XW'(cand.n) * XW'(cand.p1) * PD_X;
        mq       = (target * denom + HALF_X) / REF_X;
        in_range = (mq >= XW'(M_LO)) && (mq <= XW'(M_HI));
        achieved = (REF_X * mq) / denom;
        err      = (target > achieved) ? (target - achieved) : (achieved - target);
        m_val    = mq[FW-1:0];
    end
endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep
    import pll_search_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          valid,
    input  logic          in_range,
    input  logic [XW-1:0] err,
    input  cand_t         cand,
    input  logic [FW-1:0] m_val,
    output cand_t         best_cand,
    output logic [FW-1:0] best_m,
    output logic          found
);
    localparam logic [XW-1:0] ERR_INIT = XW'(32'hFFFF_FFFF);

    logic [XW-1:0] best_err;
    logic          take;

    assign take  = valid && in_range && (err < best_err);
    assign found = (best_err != ERR_INIT);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            best_err  <= ERR_INIT;
            best_cand <= '0;
            best_m    <= '0;
        end else if (take) begin
            best_err  <= err;
            best_cand <= cand;
            best_m    <= m_val;
        end
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int unsigned PIX_W   = 32,
    parameter int unsigned REF_KHZ = REF_KHZ_D,
    parameter int unsigned POSTDIV = POSTDIV_D,
    parameter int unsigned P1_HI   = P1_HI_D,
    parameter int unsigned N_LO    = N_LO_D,
    parameter int unsigned N_HI    = N_HI_D,
    parameter int unsigned M_LO    = M_LO_D,
    parameter int unsigned M_HI    = M_HI_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PIX_W-1:0] pix_khz,
    input  logic             dual_link,
    output logic             busy,
    output logic             done,
    output logic             not_found,
    output logic [31:0]      fp_word,
    output logic [P1_HI-1:0] p1_onehot
);
    srch_state_e   state;
    logic [XW-1:0] target;
    logic          accept;
    cand_t         cand;
    logic          last;
    logic          in_range;
    logic [XW-1:0] err;
    logic [FW-1:0] m_val;
    cand_t         best_cand;
    logic [FW-1:0] best_m;
    logic          found;
    fb_fields_t    fields;

    assign accept = (state == S_IDLE) && start;
    assign fields = pack_fields(best_cand.n, best_m);

    pll_cand_walk #(.P1_HI(P1_HI), .N_LO(N_LO), .N_HI(N_HI)) u_walk (
        .clk (clk),
        .rst (rst),
        .init(accept),
        .step(state == S_SCAN),
        .cand(cand),
        .last(last)
    );

    pll_cand_eval #(.REF_KHZ(REF_KHZ), .POSTDIV(POSTDIV),
                    .M_LO(M_LO), .M_HI(M_HI)) u_eval (
        .target  (target),
        .cand    (cand),
        .in_range(in_range),
        .err     (err),
        .m_val   (m_val)
    );

    pll_best_keep u_keep (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .valid    (state == S_SCAN),
        .in_range (in_range),
        .err      (err),
        .cand     (cand),
        .m_val    (m_val),
        .best_cand(best_cand),
        .best_m   (best_m),
        .found    (found)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            target    <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            not_found <= 1'b0;
            fp_word   <= '0;
            p1_onehot <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        target <= dual_link ? XW'(pix_khz) : (XW'(pix_khz) << 1);
                        busy   <= 1'b1;
                        state  <= S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (last) state <= S_WRAP;
                end
                S_WRAP: begin
                    busy      <= 1'b0;
                    done      <= 1'b1;
                    not_found <= !found;
                    if (found) begin
                        fp_word   <= {8'h00, fields.n_f, fields.m1_f, fields.m2_f};
                        p1_onehot <= P1_HI'(1) << (best_cand.p1 - 8'd1);
                    end else begin
                        fp_word   <= '0;
                        p1_onehot <= '0;
                    end
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk
    import pll_search_pkg::*;
#(
    parameter int unsigned P1_HI = P1_HI_D,
    parameter int unsigned N_LO  = N_LO_D,
    parameter int unsigned N_HI  = N_HI_D
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             not_found,
    input logic [31:0]      fp_word,
    input logic [P1_HI-1:0] p1_onehot
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(fp_word) && $stable(p1_onehot) && $stable(not_found)));

    p_empty_on_miss_r8: assert property (@(posedge clk) disable iff (rst)
        not_found |-> (fp_word == 32'd0 && p1_onehot == '0));

    p_onehot_sel_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !not_found) |-> ($countones(p1_onehot) == 1));

    p_field_span_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !not_found) |->
            (fp_word[31:24] == 8'd0 &&
             fp_word[7:0] >= 8'd5 && fp_word[7:0] <= 8'd9 &&
             fp_word[23:16] >= 8'(N_LO - 2) && fp_word[23:16] <= 8'(N_HI - 2)));
endmodule

bind pll_div_search pll_div_search_chk #(
    .P1_HI(P1_HI), .N_LO(N_LO), .N_HI(N_HI)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .not_found(not_found),
    .fp_word  (fp_word),
    .p1_onehot(p1_onehot)
);

// File: tb/tb_pll_div_search.sv
module tb_pll_div_search;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] pix_khz = '0;
    logic        dual_link = 1'b0;
    logic        busy, done, not_found;
    logic [31:0] fp_word;
    logic [7:0]  p1_onehot;

    int n_cmp = 0;
    int n_bad = 0;
    bit timed_out = 0;

    always #4 clk = ~clk;

    pll_div_search dut (
        .clk(clk), .rst(rst), .start(start), .pix_khz(pix_khz),
        .dual_link(dual_link), .busy(busy), .done(done),
        .not_found(not_found), .fp_word(fp_word), .p1_onehot(p1_onehot)
    );

    task automatic chk(input string req, input longint unsigned act,
                       input longint unsigned exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected result from the requirement formulas (R2..R8).
    task automatic model(input logic [31:0] pix, input bit dual,
                         output logic [31:0] e_fp, output logic [7:0] e_p1,
                         output bit e_nf);
        longint unsigned t, d, m, f, e, best, bm;
        int bp, bn;
        t = dual ? longint'(pix) : 2 * longint'(pix);
        best = 64'hFFFF_FFFF; bm = 0; bp = 0; bn = 0;
        for (int p = 1; p <= 8; p++) begin
            for (int n = 5; n <= 10; n++) begin
                d = longint'(n * p * 7);
                m = (t * d + 60000) / 120000;
                if (m < 77 || m > 131) continue;
                f = (120000 * m) / d;
                e = (t > f) ? t - f : f - t;
                if (e < best) begin best = e; bm = m; bp = p; bn = n; end
            end
        end
        e_nf = (best == 64'hFFFF_FFFF);
        if (e_nf) begin
            e_fp = 0; e_p1 = 0;
        end else begin
            longint unsigned m2, m1;
            m2 = ((bm + 3) % 5) + 7;
            m1 = (bm - m2) / 5;
            e_fp = 32'((longint'(bn - 2) << 16) | ((m1 - 2) << 8) | (m2 - 2));
            e_p1 = 8'(1 << (bp - 1));
        end
    endtask

    // Pulses start, returns the number of falling edges until done is seen.
    task automatic run(input logic [31:0] pix, input bit dual, output int lat);
        @(negedge clk);
        pix_khz = pix; dual_link = dual; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk("R9 busy after start", busy, 1);
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        if (!done) begin
            timed_out = 1;
            chk("R9 watchdog", 0, 1);
        end
    endtask

    task automatic check_result(input string tag, input logic [31:0] pix,
                                input bit dual);
        logic [31:0] e_fp; logic [7:0] e_p1; bit e_nf;
        model(pix, dual, e_fp, e_p1, e_nf);
        chk({tag, " R6 fp_word"}, fp_word, e_fp);
        chk({tag, " R7 p1_onehot"}, p1_onehot, e_p1);
        chk({tag, " R8 not_found"}, not_found, e_nf);
        chk({tag, " R9 busy low at done"}, busy, 0);
    endtask

    initial begin
        int lat;
        logic [31:0] pix;
        bit dual;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 not_found", not_found, 0);
        chk("R1 fp_word", fp_word, 0);
        chk("R1 p1_onehot", p1_onehot, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 after release", {busy, done, not_found}, 0);

        // R2 / R3 / R4 / R5: directed typical cases in both link modes
        run(32'd65000, 1'b1, lat);
        check_result("R2 dual 65MHz", 32'd65000, 1'b1);
        chk("R9 latency", lat, 50);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);

        run(32'd65000, 1'b0, lat);
        check_result("R2 single 65MHz", 32'd65000, 1'b0);

        run(32'd108000, 1'b0, lat);
        check_result("R5 single 108MHz", 32'd108000, 1'b0);

        // R3 / R8: out of the multiplier window on both sides
        run(32'd0, 1'b1, lat);
        check_result("R8 zero", 32'd0, 1'b1);
        run(32'd8000, 1'b1, lat);
        check_result("R3 low edge", 32'd8000, 1'b1);
        run(32'd460000, 1'b1, lat);
        check_result("R3 high edge", 32'd460000, 1'b1);
        // R4: exact hit at reference multiples where ties are likely
        run(32'd60000, 1'b0, lat);
        check_result("R4 tie 120MHz", 32'd60000, 1'b0);

        // R10: second start mid-search is ignored
        @(negedge clk);
        pix_khz = 32'd40000; dual_link = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        pix_khz = 32'd150000; dual_link = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 400) begin @(negedge clk); lat++; end
        if (!done) begin timed_out = 1; chk("R10 watchdog", 0, 1); end
        check_result("R10 first target kept", 32'd40000, 1'b1);

        // R11: results hold while idle inputs change
        begin
            logic [31:0] hold_fp; logic [7:0] hold_p1; logic hold_nf;
            hold_fp = fp_word; hold_p1 = p1_onehot; hold_nf = not_found;
            pix_khz = 32'd12345; dual_link = 1'b0;
            repeat (6) @(negedge clk);
            chk("R11 fp hold", fp_word, hold_fp);
            chk("R11 p1 hold", p1_onehot, hold_p1);
            chk("R11 nf hold", not_found, hold_nf);
        end

        // Random pixel clocks over the reachable band, both modes (R2..R7)
        for (int i = 0; i < 60 && !timed_out; i++) begin
            pix  = 32'd5000 + ($urandom % 32'd250000);
            dual = $urandom % 2;
            run(pix, dual, lat);
            check_result("R3 random", pix, dual);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule